// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is the slave end of a two-wire serial control bus. It lets a bus master read and write a register file that lives outside the block. The block samples the clock and data lines on a fast system clock and detects bus start and stop events from them. It recognises its own 7-bit device address and acknowledges the bytes it accepts. It only ever pulls the data line low, through an open-drain enable; it never drives the line high.

A write transaction carries a pointer byte after the address byte, followed by zero or more data bytes. The pointer byte selects a register and holds a flag that makes the pointer step forward after every byte transferred. A read transaction returns register contents from the current pointer, so a master usually sets the pointer with a short write, issues a repeated start, and then reads. The register file is attached through a simple port: the pointer is presented as an address, a one-cycle write strobe carries the data to be stored, and read data comes back combinationally. The system clock must run at least eight times faster than the bus clock.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) begins reception of a new address byte from any state, including in the middle of a transfer. A rising data line while the clock line is high (stop) returns the block to idle with the data line released.
- R2: The address byte is sent MSB first: bits 7:1 are the device address and bit 0 selects the direction (1 = read, 0 = write). The address matches when bits 7:2 equal 100101 and bit 1 equals `addr_strap`. A match is acknowledged by holding the data line low through the ninth clock pulse.
- R3: A non-matching address is not acknowledged. Until the next start, the block drives nothing and writes nothing.
- R4: In a write, the byte after the address loads the pointer: bit 7 is the increment flag and bits 6:0 are the register number. The pointer byte is acknowledged.
- R5: Each later byte of a write produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the current pointer and `reg_wr_data` equal to the byte. Each such byte is acknowledged.
- R6: With the increment flag set, the pointer advances by one, modulo 128, after each byte written or read. With the flag clear, the pointer stays where it is.
- R7: In a read, the block returns the register at the pointer MSB first, one bit per clock pulse, and changes the data line only while the clock line is low.
- R8: After a read byte, an acknowledge from the master (data low in the ninth pulse) makes the block send the next byte. A non-acknowledge makes the block release the data line and stay silent until a stop or start.
- R9: The pointer and its increment flag are kept across starts and stops. A read issued after a repeated start resumes at the pointer left by the previous transfer.
- R10: After reset the data line is released, no write is issued, and the pointer and increment flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 1 | Static strap that supplies the device address LSB |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_addr | output | 7 | Current pointer, used as the register address for reads and writes |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data to store when `reg_wr_en` is high |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` |

## Verification
Some properties are checked on every cycle: the write strobe is always a single-cycle pulse; the pointer steps by one after a write when the increment flag is set and holds when it is clear; the open-drain enable changes only while the synchronised clock line is low; and the idle state never drives the line or writes. Other behaviour shows only in the bench's bus scenarios. These are the address decode against the strap, the acknowledge in the ninth pulse, the values of bytes read back, and the handling of master acknowledge and non-acknowledge. They also include pointer wrap from 127 to 0, pointer retention across a repeated start, and the silence that follows a wrong address.

// File: rtl/i2c_reg_slave_pkg.sv
// Shared types for the two-wire register slave.
// Assumes: nothing beyond the standard language.
package i2c_reg_slave_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a start
        ST_RX,       // shifting in a byte on clock rises
        ST_ACK_WAIT, // byte taken, waiting for clock low to drive acknowledge
        ST_ACK,      // holding acknowledge through the ninth pulse
        ST_TX,       // shifting a read byte out on clock falls
        ST_MACK,     // sampling the master's acknowledge
        ST_TX_WAIT,  // master acknowledged, waiting for clock low to reload
        ST_HOLD      // silent until start or stop
    } slv_state_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } byte_kind_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises the bus clock and data lines to the system clock and flags
// clock edges plus start and stop events.
// Assumes: system clock at least 8x the bus clock; idle bus lines are high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through the synchroniser chain and keep one older copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Event decode from the synchronised and one-cycle-old samples
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_map_ptr.sv
// Register pointer with an embedded increment flag.
// A load takes the register number from the low AW bits and the flag from
// bit 7 of the pointer byte. A step advances the pointer (wrapping) only
// when the flag is set.
// Assumes: load and step never occur in the same cycle.
module i2c_map_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    load_val,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          incr
);

    localparam int FLAG_BIT = 7;

    // Hold, load or advance the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            incr <= 1'b0;
        end else if (load) begin
            ptr  <= load_val[AW-1:0];
            incr <= load_val[FLAG_BIT];
        end else if (step && incr) begin
            ptr  <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
// Two-wire slave giving byte access to an external register file through a
// pointer. It decodes start and stop, matches a 7-bit address whose LSB
// comes from a strap, loads the pointer on writes and streams data.
// Assumes: system clock at least 8x the bus clock; addr_strap is static;
// reg_rd_data is a combinational function of reg_addr.
module i2c_reg_slave
    import i2c_reg_slave_pkg::*;
#(
    parameter int         AW          = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ADDR_HI = 6'b100101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          addr_strap,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr_en,
    output logic [7:0]    reg_wr_data,
    input  logic [7:0]    reg_rd_data
);

    localparam int BW = 8;
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    slv_state_e    state_q;
    byte_kind_e    kind_q;
    logic          rw_q;
    logic [CW-1:0] cnt_q;
    logic [BW-2:0] sr_q;
    logic [BW-1:0] tx_q;
    logic          sda_oe_q;
    logic          wr_en_q;
    logic [BW-1:0] wr_data_q;

    logic [BW-1:0] rx_byte;
    logic          byte_done;
    logic          addr_hit;
    logic          ptr_load;
    logic          ptr_step;
    logic          ptr_incr;
    logic          fsm_idle;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_map_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx_byte),
        .step     (ptr_step),
        .ptr      (reg_addr),
        .incr     (ptr_incr)
    );

    // Byte assembly, address decode and pointer control strobes
    always_comb begin
        rx_byte   = {sr_q, sda_s};
        byte_done = (state_q == ST_RX) && scl_rise && (cnt_q == LAST_BIT);
        addr_hit  = (rx_byte[7:2] == DEV_ADDR_HI) && (rx_byte[1] == addr_strap);
        ptr_load  = byte_done && (kind_q == K_PTR);
        // the write step is delayed one cycle so the strobe sees the old pointer
        ptr_step  = wr_en_q ||
                    ((state_q == ST_TX) && scl_fall && (cnt_q == LAST_BIT));
        fsm_idle  = (state_q == ST_IDLE);
    end

    // Protocol engine: bus events drive the state, shifters and line enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= K_ADDR;
            rw_q      <= 1'b0;
            cnt_q     <= '0;
            sr_q      <= '0;
            tx_q      <= '0;
            sda_oe_q  <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state_q  <= ST_RX;
                kind_q   <= K_ADDR;
                cnt_q    <= '0;
                sda_oe_q <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (scl_rise) begin
                            sr_q  <= rx_byte[BW-2:0];
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) begin
                                case (kind_q)
                                    K_ADDR: begin
                                        rw_q    <= rx_byte[0];
                                        state_q <= addr_hit ? ST_ACK_WAIT : ST_IDLE;
                                    end
                                    K_PTR: state_q <= ST_ACK_WAIT;
                                    default: begin
                                        wr_en_q   <= 1'b1;
                                        wr_data_q <= rx_byte;
                                        state_q   <= ST_ACK_WAIT;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe_q <= 1'b1;
                            state_q  <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (kind_q == K_ADDR && rw_q) begin
                                tx_q     <= reg_rd_data;
                                sda_oe_q <= ~reg_rd_data[BW-1];
                                state_q  <= ST_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                kind_q   <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
                                state_q  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == LAST_BIT) begin
                                sda_oe_q <= 1'b0;
                                state_q  <= ST_MACK;
                            end else begin
                                tx_q     <= {tx_q[BW-2:0], 1'b0};
                                sda_oe_q <= ~tx_q[BW-2];
                                cnt_q    <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            state_q <= sda_s ? ST_HOLD : ST_TX_WAIT;
                        end
                    end
                    ST_TX_WAIT: begin
                        if (scl_fall) begin
                            cnt_q    <= '0;
                            tx_q     <= reg_rd_data;
                            sda_oe_q <= ~reg_rd_data[BW-1];
                            state_q  <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output wiring
    assign sda_oe      = sda_oe_q;
    assign reg_wr_en   = wr_en_q;
    assign reg_wr_data = wr_data_q;

endmodule

// File: rtl/i2c_reg_slave_chk.sv
// Cycle-level properties of the register slave, bound to every instance.
// Assumes: inputs are the top's ports and a few internal status signals.
module i2c_reg_slave_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_addr,
    input logic          ptr_incr,
    input logic          scl_s,
    input logic          fsm_idle
);

    // R5: a write strobe lasts exactly one cycle
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R6: flag set, pointer moves up by one after a write
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && ptr_incr) |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

    // R6: flag clear, pointer holds after a write
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !ptr_incr) |=> $stable(reg_addr));

    // R7: the line enable only changes while the clock line is low
    assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R3: the idle state neither drives the line nor writes
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> (!sda_oe && !reg_wr_en));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .ptr_incr  (ptr_incr),
    .scl_s     (scl_s),
    .fsm_idle  (fsm_idle)
);

// File: tb/tb_i2c_reg_slave.sv
// Bench: a behavioural bus master, a register-file stub and a reference
// model of pointer and contents; write strobes are compared on every clock.
module tb_i2c_reg_slave;

    localparam int AW  = 7;
    localparam int QTR = 5;          // system clocks per quarter bus period
    localparam int NREG = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          strap = 1'b0;
    logic          sda_oe;
    logic [AW-1:0] reg_addr;
    logic          reg_wr_en;
    logic [7:0]    reg_wr_data;
    logic [7:0]    reg_rd_data;
    logic          sda_bus;

    logic [7:0]    regfile [NREG];
    logic [7:0]    mregs   [NREG];
    logic [AW-1:0] mptr = '0;
    logic          mincr = 1'b0;
    logic [14:0]   exp_q [$];
    int            n_chk = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    assign sda_bus     = m_sda & ~sda_oe;
    assign reg_rd_data = regfile[reg_addr];

    i2c_reg_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .addr_strap  (strap),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    // register file stub
    always @(posedge clk) if (reg_wr_en) regfile[reg_addr] <= reg_wr_data;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // every clock: any strobe must match the next expected write
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected write", {reg_addr, reg_wr_data}, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wr_data} == e, "R5", "write addr/data",
                      {reg_addr, reg_wr_data}, e);
            end
        end
    end

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_bus; q(); m_scl = 1'b0; q();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
        check(sda_oe == 1'b0, "R1", "line released after stop", sda_oe, 0);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input logic exp_ack,
                             input string req);
        logic ak;
        send_byte({a, rw}, ak);
        check(ak == exp_ack, req, "address acknowledge", ak, exp_ack);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic ak;
        send_byte(p, ak);
        check(ak, "R4", "pointer byte acknowledge", ak, 1);
        mptr  = p[AW-1:0];
        mincr = p[7];
    endtask

    task automatic put_data(input logic [7:0] d);
        logic ak;
        exp_q.push_back({mptr, d});
        mregs[mptr] = d;
        if (mincr) mptr = mptr + 1'b1;
        send_byte(d, ak);
        check(ak, "R5", "data byte acknowledge", ak, 1);
    endtask

    task automatic get_data(input logic m_ack, input string req);
        logic [7:0] d;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~m_ack);
        check(d == mregs[mptr], req, "read byte", d, mregs[mptr]);
        if (mincr) mptr = mptr + 1'b1;
    endtask

    function automatic logic [6:0] dev(input logic lsb);
        return {6'b100101, lsb};
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic b;
        logic ak;
        for (int i = 0; i < NREG; i++) begin
            regfile[i] = 8'(i * 3 + 1);
            mregs[i]   = 8'(i * 3 + 1);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sda_oe == 1'b0, "R10", "line released after reset", sda_oe, 0);
        check(reg_wr_en == 1'b0, "R10", "no write after reset", reg_wr_en, 0);
        check(reg_addr == '0, "R10", "pointer zero after reset", reg_addr, 0);

        // R2 R4 R5 R6: incrementing block write
        bus_start();
        send_addr(dev(1'b0), 1'b0, 1'b1, "R2");
        set_ptr(8'h90);
        put_data(8'hA1); put_data(8'hB2); put_data(8'hC3);
        bus_stop();
        check(reg_addr == mptr, "R6", "pointer after block write", reg_addr, mptr);

        // R6: fixed pointer write
        bus_start();
        send_addr(dev(1'b0), 1'b0, 1'b1, "R2");
        set_ptr(8'h20);
        put_data(8'h11); put_data(8'h22);
        bus_stop();
        check(reg_addr == 7'h20, "R6", "pointer held without flag", reg_addr, 7'h20);

        // R7 R8 R9: pointer set, repeated start, incrementing read
        bus_start();
        send_addr(dev(1'b0), 1'b0, 1'b1, "R2");
        set_ptr(8'h90);
        bus_start();
        send_addr(dev(1'b0), 1'b1, 1'b1, "R9");
        get_data(1'b1, "R7"); get_data(1'b1, "R8"); get_data(1'b0, "R9");
        recv_bit(b);
        check(b == 1'b1, "R8", "line silent after master nack", b, 1);
        bus_stop();

        // R9: read with no pointer set resumes at kept pointer
        bus_start();
        send_addr(dev(1'b0), 1'b1, 1'b1, "R9");
        get_data(1'b0, "R9");
        bus_stop();

        // R6: fixed pointer read repeats the same register
        bus_start();
        send_addr(dev(1'b0), 1'b0, 1'b1, "R2");
        set_ptr(8'h20);
        bus_start();
        send_addr(dev(1'b0), 1'b1, 1'b1, "R2");
        get_data(1'b1, "R6"); get_data(1'b0, "R6");
        bus_stop();

        // R3: wrong strap bit and wrong fixed bits are ignored
        bus_start();
        send_addr(dev(1'b1), 1'b0, 1'b0, "R3");
        send_byte(8'h85, ak);
        check(ak == 1'b0, "R3", "no ack after mismatch", ak, 0);
        send_byte(8'h55, ak);
        check(ak == 1'b0, "R3", "no ack for data after mismatch", ak, 0);
        bus_stop();
        bus_start();
        send_addr(7'h2A, 1'b0, 1'b0, "R3");
        bus_stop();
        check(reg_addr == 7'h20, "R3", "pointer untouched by mismatch", reg_addr, 7'h20);

        // R2: strap high changes the matching address
        strap = 1'b1;
        bus_start();
        send_addr(dev(1'b0), 1'b0, 1'b0, "R2");
        bus_start();
        send_addr(dev(1'b1), 1'b0, 1'b1, "R2");
        set_ptr(8'h05);
        put_data(8'h5A);
        bus_start();
        send_addr(dev(1'b1), 1'b1, 1'b1, "R2");
        get_data(1'b0, "R7");
        bus_stop();

        // R1: repeated start in the middle of a write restarts address reception
        bus_start();
        send_addr(dev(1'b1), 1'b0, 1'b1, "R1");
        set_ptr(8'h81);
        put_data(8'h77);
        bus_start();
        send_addr(dev(1'b1), 1'b1, 1'b1, "R1");
        get_data(1'b0, "R1");
        bus_stop();

        // R6: wrap from 127 to 0
        bus_start();
        send_addr(dev(1'b1), 1'b0, 1'b1, "R2");
        set_ptr(8'hFF);
        put_data(8'hE1); put_data(8'hE2);
        bus_stop();
        check(reg_addr == 7'h01, "R6", "pointer after wrap", reg_addr, 7'h01);
        bus_start();
        send_addr(dev(1'b1), 1'b0, 1'b1, "R2");
        set_ptr(8'h7F);
        bus_start();
        send_addr(dev(1'b1), 1'b1, 1'b1, "R6");
        get_data(1'b1, "R6"); get_data(1'b0, "R6");
        bus_stop();

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all expected writes seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule